// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a translation miss for a paged 32-bit address space. Given the base of a page directory, a linear address and the kind of access wanted (user or supervisor, read or write), it reads the directory entry, then the table entry it points to. It verifies both entries are present, merges their protection attributes into one mode, and checks the requested access against that mode. A write-protect input decides whether supervisor writes honour read-only user pages.

On success it brings the accessed flag of both entries, and the dirty flag of the table entry for a write, up to date in memory. It writes back only the entries whose value actually changes, and writes the table entry before the directory entry. It then presents a fill record for the translation cache: page frame, merged mode, and a dirty bit. On failure it reports a page fault with a three-bit error code and the faulting linear address. Memory is reached through a single request port that keeps one request outstanding until a response strobe arrives.

Top module: `pt_walker`

## Requirements
- R1: After `start` is accepted, the first request is a read at `(base_addr & 0xFFFFF000) + lin_addr[31:22]*4`.
- R2: Once the directory entry is present (bit 0 set), the second request is a read at `(directory entry & 0xFFFFF000) + lin_addr[21:12]*4`.
- R3: If the directory entry or the table entry has bit 0 clear, the walk ends with `fault` and `fault_code = {acc_user, acc_write, 0}`. `fault_lin` equals the walk's linear address. No write is issued, and a missing directory entry stops the walk before the table read.
- R4: The merged mode is the 2-bit value {bit 2 (user), bit 1 (writable)} of whichever entry has the numerically smaller such value. On a tie the table entry's value is used.
- R5: With merged mode M, an access is denied if any of these holds: it is a user access and M[1]=0; it is a user write and M[0]=0; or it is a supervisor write, `wp_mode`=1 and M=2'b10. A denial ends the walk with `fault` and `fault_code = {acc_user, acc_write, 1}`, with no write issued.
- R6: On an allowed access, the table entry is updated to OR bit 5, plus bit 6 for a write. The directory entry is updated to OR bit 5. Each is written back only if the new value differs from the one read.
- R7: When both entries are written back, the table entry write is issued before the directory entry write.
- R8: A successful walk ends with a one-cycle `done`, never together with `fault`. At that point `fill_frame` = table entry bits 31:12, {`fill_user`,`fill_write`} = merged mode, and `fill_dirty` = `acc_write`.
- R9: `busy` is high from the cycle after an accepted `start` until the cycle after `done` or `fault`. `start` is ignored while busy. A request holds its address and write flag until `mem_rvalid`.
- R10: After reset `busy`, `mem_req`, `done` and `fault` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a walk (accepted only when idle) |
| base_addr | input | 32 | Page directory base; low 12 bits ignored |
| lin_addr | input | 32 | Linear address to translate |
| acc_user | input | 1 | Access made at user level |
| acc_write | input | 1 | Access is a write |
| wp_mode | input | 1 | Supervisor writes honour read-only user pages |
| busy | output | 1 | Walk in progress |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Request byte address |
| mem_wdata | output | 32 | Write data |
| mem_rvalid | input | 1 | Response strobe, completes the held request |
| mem_rdata | input | 32 | Read data, valid with `mem_rvalid` |
| done | output | 1 | One-cycle success strobe |
| fill_frame | output | 20 | Physical frame for the fill |
| fill_user | output | 1 | Merged mode, user bit |
| fill_write | output | 1 | Merged mode, writable bit |
| fill_dirty | output | 1 | Fill dirty bit |
| fault | output | 1 | One-cycle page-fault strobe |
| fault_code | output | 3 | {user, write, protection} error code |
| fault_lin | output | 32 | Faulting linear address |

## Verification
The bench sweeps every combination of the directory and table present, user and writable bits, every access kind, both write-protect settings, and all states of the accessed and dirty flags. Each walk also uses a different directory index, table index, frame and response latency. The present-bit patterns separate the two not-present faults from each other and from protection faults. The user/writable patterns separate the smaller-value merge, including its tie, from a plain AND or OR of the bits. The flag patterns show whether each write-back is issued, skipped or misordered. A directed case raises `start` with a different address in the middle of a walk, to show it is ignored.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

   localparam int unsigned FLAG_P  = 0;
   localparam int unsigned FLAG_RW = 1;
   localparam int unsigned FLAG_US = 2;
   localparam int unsigned FLAG_A  = 5;
   localparam int unsigned FLAG_D  = 6;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD_DIR,
      ST_RD_TBL,
      ST_CHECK,
      ST_WR_TBL,
      ST_WR_DIR,
      ST_DONE,
      ST_FAULT
   } walk_state_e;

   typedef struct packed {
      logic user;
      logic write;
   } pg_mode_t;

endpackage

// File: rtl/pt_walker_addr.sv
module pt_walker_addr #(
   parameter int ADDR_W  = 32,
   parameter int PAGE_W  = 12,
   parameter int IDX_W   = 10,
   parameter int ENT_LOG = 2
) (
   input  logic [ADDR_W-PAGE_W-1:0] base_frame,
   input  logic [ADDR_W-PAGE_W-1:0] dir_frame,
   input  logic [IDX_W-1:0]         dir_idx,
   input  logic [IDX_W-1:0]         tbl_idx,
   output logic [ADDR_W-1:0]        dir_addr,
   output logic [ADDR_W-1:0]        tbl_addr
);
   localparam int PAD_W = ADDR_W - IDX_W;

   if (IDX_W + ENT_LOG > PAGE_W) begin : g_bad_slot
      $error("a table of entries must fit inside one page");
   end

   logic [ADDR_W-1:0] dir_off;
   logic [ADDR_W-1:0] tbl_off;

   always_comb begin
      dir_off  = {{PAD_W{1'b0}}, dir_idx} << ENT_LOG;
      tbl_off  = {{PAD_W{1'b0}}, tbl_idx} << ENT_LOG;
      dir_addr = {base_frame, {PAGE_W{1'b0}}} + dir_off;
      tbl_addr = {dir_frame,  {PAGE_W{1'b0}}} + tbl_off;
   end
endmodule

// File: rtl/pt_walker_prot.sv
module pt_walker_prot
   import pt_walker_pkg::*;
#(
   parameter bit HONOR_WP = 1'b1
) (
   input  pg_mode_t dir_mode,
   input  pg_mode_t tbl_mode,
   input  logic     need_user,
   input  logic     need_write,
   input  logic     wp,
   output pg_mode_t eff_mode,
   output logic     deny
);
   logic wp_eff;

   if (HONOR_WP) begin : g_wp_on
      assign wp_eff = wp;
   end else begin : g_wp_off
      logic unused_wp;
      assign unused_wp = wp;
      assign wp_eff    = 1'b0;
   end

   always_comb begin
      eff_mode = (dir_mode < tbl_mode) ? dir_mode : tbl_mode;
      unique case ({need_user, need_write})
         2'b00:   deny = 1'b0;
         2'b01:   deny = wp_eff && eff_mode.user && !eff_mode.write;
         2'b10:   deny = !eff_mode.user;
         default: deny = !(eff_mode.user && eff_mode.write);
      endcase
   end
endmodule

// File: rtl/pt_walker_upd.sv
module pt_walker_upd
   import pt_walker_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter bit CAN_DIRTY = 1'b1
) (
   input  logic [ADDR_W-1:0] entry,
   input  logic              set_dirty,
   output logic [ADDR_W-1:0] entry_new,
   output logic              changed
);
   localparam logic [ADDR_W-1:0] MASK_A = ADDR_W'(1) << FLAG_A;
   localparam logic [ADDR_W-1:0] MASK_D = ADDR_W'(1) << FLAG_D;

   if (CAN_DIRTY) begin : g_dirty
      assign entry_new = entry | MASK_A | (set_dirty ? MASK_D : '0);
   end else begin : g_clean
      logic unused_sd;
      assign unused_sd = set_dirty;
      assign entry_new = entry | MASK_A;
   end

   assign changed = (entry_new != entry);
endmodule

// File: rtl/pt_walker.sv
module pt_walker
   import pt_walker_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int PAGE_W   = 12,
   parameter int IDX_W    = 10,
   parameter int ENT_LOG  = 2,
   parameter bit HONOR_WP = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start,
   input  logic [ADDR_W-1:0]        base_addr,
   input  logic [ADDR_W-1:0]        lin_addr,
   input  logic                     acc_user,
   input  logic                     acc_write,
   input  logic                     wp_mode,
   output logic                     busy,
   output logic                     mem_req,
   output logic                     mem_we,
   output logic [ADDR_W-1:0]        mem_addr,
   output logic [ADDR_W-1:0]        mem_wdata,
   input  logic                     mem_rvalid,
   input  logic [ADDR_W-1:0]        mem_rdata,
   output logic                     done,
   output logic [ADDR_W-PAGE_W-1:0] fill_frame,
   output logic                     fill_user,
   output logic                     fill_write,
   output logic                     fill_dirty,
   output logic                     fault,
   output logic [2:0]               fault_code,
   output logic [ADDR_W-1:0]        fault_lin
);
   localparam int FRAME_W  = ADDR_W - PAGE_W;
   localparam int N_LEVELS = 2;
   localparam int LVL_TBL  = 0;
   localparam int LVL_DIR  = 1;

   if (ADDR_W != PAGE_W + N_LEVELS * IDX_W) begin : g_bad_split
      $error("address width must equal page offset plus two index fields");
   end
   if (PAGE_W <= FLAG_D) begin : g_bad_page
      $error("page offset must leave room for the entry flag bits");
   end

   walk_state_e          state;
   logic [FRAME_W-1:0]   base_q;
   logic [ADDR_W-1:0]    lin_q;
   logic                 user_q;
   logic                 write_q;
   logic                 wp_q;
   logic                 prot_q;
   logic [ADDR_W-1:0]    pde_q;
   logic [ADDR_W-1:0]    pte_q;

   logic [ADDR_W-1:0]    dir_addr;
   logic [ADDR_W-1:0]    tbl_addr;
   pg_mode_t             eff_mode;
   logic                 deny;

   logic [ADDR_W-1:0]    ent_cur [N_LEVELS];
   logic [ADDR_W-1:0]    ent_new [N_LEVELS];
   logic                 ent_chg [N_LEVELS];

   logic                 unused_base_low;
   assign unused_base_low = ^base_addr[PAGE_W-1:0];

   pt_walker_addr #(
      .ADDR_W  (ADDR_W),
      .PAGE_W  (PAGE_W),
      .IDX_W   (IDX_W),
      .ENT_LOG (ENT_LOG)
   ) u_addr (
      .base_frame (base_q),
      .dir_frame  (pde_q[ADDR_W-1:PAGE_W]),
      .dir_idx    (lin_q[ADDR_W-1 -: IDX_W]),
      .tbl_idx    (lin_q[PAGE_W +: IDX_W]),
      .dir_addr   (dir_addr),
      .tbl_addr   (tbl_addr)
   );

   pt_walker_prot #(
      .HONOR_WP (HONOR_WP)
   ) u_prot (
      .dir_mode   ('{user: pde_q[FLAG_US], write: pde_q[FLAG_RW]}),
      .tbl_mode   ('{user: pte_q[FLAG_US], write: pte_q[FLAG_RW]}),
      .need_user  (user_q),
      .need_write (write_q),
      .wp         (wp_q),
      .eff_mode   (eff_mode),
      .deny       (deny)
   );

   assign ent_cur[LVL_TBL] = pte_q;
   assign ent_cur[LVL_DIR] = pde_q;

   for (genvar g = 0; g < N_LEVELS; g++) begin : g_upd
      pt_walker_upd #(
         .ADDR_W    (ADDR_W),
         .CAN_DIRTY (g == LVL_TBL)
      ) u_upd (
         .entry     (ent_cur[g]),
         .set_dirty (write_q),
         .entry_new (ent_new[g]),
         .changed   (ent_chg[g])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         base_q  <= '0;
         lin_q   <= '0;
         user_q  <= 1'b0;
         write_q <= 1'b0;
         wp_q    <= 1'b0;
         prot_q  <= 1'b0;
         pde_q   <= '0;
         pte_q   <= '0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (start) begin
                  base_q  <= base_addr[ADDR_W-1:PAGE_W];
                  lin_q   <= lin_addr;
                  user_q  <= acc_user;
                  write_q <= acc_write;
                  wp_q    <= wp_mode;
                  prot_q  <= 1'b0;
                  state   <= ST_RD_DIR;
               end
            end
            ST_RD_DIR: begin
               if (mem_rvalid) begin
                  pde_q <= mem_rdata;
                  state <= mem_rdata[FLAG_P] ? ST_RD_TBL : ST_FAULT;
               end
            end
            ST_RD_TBL: begin
               if (mem_rvalid) begin
                  pte_q <= mem_rdata;
                  state <= mem_rdata[FLAG_P] ? ST_CHECK : ST_FAULT;
               end
            end
            ST_CHECK: begin
               if (deny) begin
                  prot_q <= 1'b1;
                  state  <= ST_FAULT;
               end else if (ent_chg[LVL_TBL]) begin
                  state <= ST_WR_TBL;
               end else if (ent_chg[LVL_DIR]) begin
                  state <= ST_WR_DIR;
               end else begin
                  state <= ST_DONE;
               end
            end
            ST_WR_TBL: begin
               if (mem_rvalid) begin
                  state <= ent_chg[LVL_DIR] ? ST_WR_DIR : ST_DONE;
               end
            end
            ST_WR_DIR: begin
               if (mem_rvalid) begin
                  state <= ST_DONE;
               end
            end
            ST_DONE:  state <= ST_IDLE;
            ST_FAULT: state <= ST_IDLE;
            default:  state <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = tbl_addr;
      mem_wdata = ent_new[LVL_DIR];
      unique case (state)
         ST_RD_DIR: begin
            mem_req  = 1'b1;
            mem_addr = dir_addr;
         end
         ST_RD_TBL: begin
            mem_req  = 1'b1;
         end
         ST_WR_TBL: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_wdata = ent_new[LVL_TBL];
         end
         ST_WR_DIR: begin
            mem_req  = 1'b1;
            mem_we   = 1'b1;
            mem_addr = dir_addr;
         end
         default: ;
      endcase
   end

   assign busy       = (state != ST_IDLE);
   assign done       = (state == ST_DONE);
   assign fault      = (state == ST_FAULT);
   assign fill_frame = pte_q[ADDR_W-1:PAGE_W];
   assign fill_user  = eff_mode.user;
   assign fill_write = eff_mode.write;
   assign fill_dirty = write_q;
   assign fault_code = {user_q, write_q, prot_q};
   assign fault_lin  = lin_q;

endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk
   import pt_walker_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int PAGE_W = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic [ADDR_W-1:0] base_addr,
   input logic              busy,
   input logic              mem_req,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [ADDR_W-1:0] mem_wdata,
   input logic              mem_rvalid,
   input logic              done,
   input logic              fault
);
   // R9: requests only while a walk is in progress
   a_r9_req_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> busy);

   // R9: a request is held unchanged until its response
   a_r9_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

   // R1: the first request reads inside the directory page
   a_r1_first_read_dir: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> (mem_req && !mem_we &&
                            mem_addr[ADDR_W-1:PAGE_W] == $past(base_addr[ADDR_W-1:PAGE_W])));

   // R8: success and fault never coincide
   a_r8_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && fault));

   // R8: done lasts one cycle
   a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R6: every write-back carries the accessed flag
   a_r6_writes_accessed: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> mem_wdata[FLAG_A]);
endmodule

bind pt_walker pt_walker_chk #(
   .ADDR_W (ADDR_W),
   .PAGE_W (PAGE_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start      (start),
   .base_addr  (base_addr),
   .busy       (busy),
   .mem_req    (mem_req),
   .mem_we     (mem_we),
   .mem_addr   (mem_addr),
   .mem_wdata  (mem_wdata),
   .mem_rvalid (mem_rvalid),
   .done       (done),
   .fault      (fault)
);

// File: tb/pt_walker_tb_top.sv
`timescale 1ns/1ps
module pt_walker_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] base_addr = '0;
   logic [31:0] lin_addr = '0;
   logic        acc_user = 1'b0;
   logic        acc_write = 1'b0;
   logic        wp_mode = 1'b0;
   logic        busy, mem_req, mem_we;
   logic [31:0] mem_addr, mem_wdata;
   logic        mem_rvalid = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic        done, fill_user, fill_write, fill_dirty, fault;
   logic [19:0] fill_frame;
   logic [2:0]  fault_code;
   logic [31:0] fault_lin;

   always #4 clk = ~clk;

   pt_walker dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
      .lin_addr(lin_addr), .acc_user(acc_user), .acc_write(acc_write),
      .wp_mode(wp_mode), .busy(busy), .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid),
      .mem_rdata(mem_rdata), .done(done), .fill_frame(fill_frame),
      .fill_user(fill_user), .fill_write(fill_write), .fill_dirty(fill_dirty),
      .fault(fault), .fault_code(fault_code), .fault_lin(fault_lin)
   );

   int n_chk = 0;
   int n_fail = 0;

   logic [31:0] mem [0:4095];
   int          lat_cfg = 0;
   int          lat_cnt = 0;
   int          tr_n = 0;
   logic [31:0] tr_addr [0:7];
   logic        tr_we   [0:7];
   logic [31:0] tr_wd   [0:7];

   // memory model: answers the held request after lat_cfg idle cycles
   always @(negedge clk) begin
      if (!rst_n) begin
         mem_rvalid = 1'b0;
         lat_cnt = 0;
      end else if (mem_rvalid) begin
         mem_rvalid = 1'b0;
      end else if (mem_req) begin
         if (lat_cnt >= lat_cfg) begin
            lat_cnt = 0;
            if (tr_n < 8) begin
               tr_addr[tr_n] = mem_addr;
               tr_we[tr_n]   = mem_we;
               tr_wd[tr_n]   = mem_wdata;
            end
            tr_n = tr_n + 1;
            if (mem_we) mem[mem_addr[13:2]] = mem_wdata;
            else        mem_rdata = mem[mem_addr[13:2]];
            mem_rvalid = 1'b1;
         end else begin
            lat_cnt = lat_cnt + 1;
         end
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk = n_chk + 1;
      if (!ok) begin
         n_fail = n_fail + 1;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wait_end(output bit timed_out);
      int to = 0;
      while (!(done || fault) && to < 200) begin
         @(negedge clk);
         to = to + 1;
      end
      timed_out = (to >= 200);
   endtask

   task automatic run_walk(input logic [31:0] base, input logic [31:0] lin, input bit u,
                           input bit w, input bit wp, input logic [31:0] pde,
                           input logic [31:0] pte, input int lat);
      logic [31:0] dir_a, tbl_a, new_pte, new_pde;
      logic [31:0] e_addr [0:3];
      logic        e_we   [0:3];
      logic [31:0] e_wd   [0:3];
      int          n_exp;
      bit          exp_fault, deny, tmo;
      logic [1:0]  dm, tm, m;
      logic [2:0]  exp_code;

      dir_a = (base & 32'hFFFF_F000) + {20'd0, lin[31:22], 2'b00};
      tbl_a = (pde & 32'hFFFF_F000) + {20'd0, lin[21:12], 2'b00};
      mem[dir_a[13:2]] = pde;
      if (pde[0]) mem[tbl_a[13:2]] = pte;

      dm = {pde[2], pde[1]};
      tm = {pte[2], pte[1]};
      m  = (dm < tm) ? dm : tm;
      deny = 1'b0;
      if (u && !m[1]) deny = 1'b1;
      if (u && w && !m[0]) deny = 1'b1;
      if (!u && w && wp && m == 2'b10) deny = 1'b1;
      new_pte = pte | 32'h20 | (w ? 32'h40 : 32'h0);
      new_pde = pde | 32'h20;

      e_addr[0] = dir_a; e_we[0] = 1'b0; e_wd[0] = '0;
      n_exp = 1;
      exp_fault = 1'b1;
      exp_code = {u, w, 1'b0};
      if (pde[0]) begin
         e_addr[1] = tbl_a; e_we[1] = 1'b0; e_wd[1] = '0;
         n_exp = 2;
         if (pte[0]) begin
            if (deny) begin
               exp_code = {u, w, 1'b1};
            end else begin
               exp_fault = 1'b0;
               if (new_pte != pte) begin
                  e_addr[n_exp] = tbl_a; e_we[n_exp] = 1'b1; e_wd[n_exp] = new_pte;
                  n_exp = n_exp + 1;
               end
               if (new_pde != pde) begin
                  e_addr[n_exp] = dir_a; e_we[n_exp] = 1'b1; e_wd[n_exp] = new_pde;
                  n_exp = n_exp + 1;
               end
            end
         end
      end

      tr_n = 0;
      lat_cfg = lat;
      start = 1'b1; base_addr = base; lin_addr = lin;
      acc_user = u; acc_write = w; wp_mode = wp;
      @(negedge clk);
      start = 1'b0;
      wait_end(tmo);
      chk(!tmo, "R8 walk completes", {31'd0, tmo}, 32'd0);
      chk(fault == exp_fault && done == !exp_fault, "R3/R5/R8 outcome (R3 R5)",
          {30'd0, done, fault}, {30'd0, !exp_fault, exp_fault});
      if (exp_fault) begin
         chk(fault_code == exp_code, "R3/R5 fault_code (R5)", {29'd0, fault_code}, {29'd0, exp_code});
         chk(fault_lin == lin, "R3 fault_lin", fault_lin, lin);
      end else begin
         chk(fill_frame == pte[31:12], "R8 fill_frame", {12'd0, fill_frame}, {12'd0, pte[31:12]});
         chk({fill_user, fill_write} == m, "R4 merged mode", {30'd0, fill_user, fill_write}, {30'd0, m});
         chk(fill_dirty == w, "R8 fill_dirty", {31'd0, fill_dirty}, {31'd0, w});
         chk(mem[tbl_a[13:2]] == new_pte, "R6 table entry in memory", mem[tbl_a[13:2]], new_pte);
         chk(mem[dir_a[13:2]] == new_pde, "R6 directory entry in memory", mem[dir_a[13:2]], new_pde);
      end
      chk(tr_n == n_exp, "R3/R6 request count (R6)", tr_n, n_exp);
      for (int i = 0; i < 4; i++) begin
         if (i < n_exp && i < tr_n) begin
            chk(tr_addr[i] == e_addr[i], (i == 0) ? "R1 request address" :
                (i == 1) ? "R2 request address" : "R7 write-back address order",
                tr_addr[i], e_addr[i]);
            chk(tr_we[i] == e_we[i], "R7 request kind", {31'd0, tr_we[i]}, {31'd0, e_we[i]});
            if (e_we[i]) chk(tr_wd[i] == e_wd[i], "R6 write data", tr_wd[i], e_wd[i]);
         end
      end
      @(negedge clk);
   endtask

   // watchdog
   initial begin
      repeat (190000) @(posedge clk);
      n_chk = n_chk + 1;
      n_fail = n_fail + 1;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      int k;
      bit tmo;
      for (int i = 0; i < 4096; i++) mem[i] = '0;
      repeat (3) @(negedge clk);
      // R10: reset state
      chk(busy == 1'b0 && mem_req == 1'b0 && done == 1'b0 && fault == 1'b0, "R10 reset outputs",
          {28'd0, busy, mem_req, done, fault}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy == 1'b0 && mem_req == 1'b0, "R10 idle after reset", {30'd0, busy, mem_req}, 32'd0);

      // R9: start ignored while busy
      lat_cfg = 2;
      mem[(32'h1004 >> 2) & 12'hFFF] = 32'h0000_2027;
      mem[(32'h2004 >> 2) & 12'hFFF] = 32'h1234_5067;
      tr_n = 0;
      start = 1'b1; base_addr = 32'h0000_1000; lin_addr = 32'h0040_1234;
      acc_user = 1'b1; acc_write = 1'b0; wp_mode = 1'b0;
      @(negedge clk);
      start = 1'b0;
      chk(busy == 1'b1, "R9 busy after start", {31'd0, busy}, 32'd1);
      @(negedge clk);
      start = 1'b1; base_addr = 32'h0000_1800; lin_addr = 32'h0080_2000;
      @(negedge clk);
      start = 1'b0;
      wait_end(tmo);
      chk(done == 1'b1, "R9 first walk finishes", {31'd0, done}, 32'd1);
      chk(tr_n == 2, "R9 no extra requests", tr_n, 2);
      chk(tr_addr[0] == 32'h1004 && tr_addr[1] == 32'h2004, "R9 addresses of first walk",
          tr_addr[1], 32'h2004);
      chk(fill_frame == 20'h12345, "R9 fill of first walk", {12'd0, fill_frame}, 32'h12345);
      @(negedge clk);
      chk(busy == 1'b0 && !mem_req, "R9 idle after done", {30'd0, busy, mem_req}, 32'd0);
      repeat (3) @(negedge clk);
      chk(tr_n == 2 && busy == 1'b0, "R9 ignored start left no walk", tr_n, 2);

      // near-exhaustive sweep of flags, access kinds, write-protect and A/D states
      k = 0;
      for (int pf = 0; pf < 8; pf++)
         for (int tf = 0; tf < 8; tf++)
            for (int acc = 0; acc < 4; acc++)
               for (int wp = 0; wp < 2; wp++)
                  for (int ad = 0; ad < 8; ad++) begin
                     logic [31:0] kk, lin, pde, pte, hsh;
                     kk  = k;
                     hsh = kk * 32'h9E37_79B1;
                     lin = {kk[9:0], 10'(kk * 37), 12'(kk * 13)};
                     pde = (kk[0] ? 32'h0000_3000 : 32'h0000_2000) | pf[2:0] |
                           (ad[0] ? 32'h20 : 32'h0) | (kk[3] ? 32'h40 : 32'h0);
                     pte = (hsh & 32'hFFFF_F000) | tf[2:0] |
                           (ad[1] ? 32'h20 : 32'h0) | (ad[2] ? 32'h40 : 32'h0);
                     run_walk(32'h0000_1ABC, lin, acc[1], acc[0], wp[0], pde, pte, k % 3);
                     k = k + 1;
                  end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule